// File: doc/BRIEF.md
# Ten-Bit-Address I2C Write Receiver

This block is the receive side of an I2C target that answers to a 10-bit address. It oversamples SCL and SDA on the system clock through synchronizer chains and finds START, repeated START and STOP conditions. From these it walks a two-byte address decode. The first byte after a START must carry the 10-bit marker, the two high address bits and a write direction. The second byte must equal the eight low address bits. Bytes that follow are data bytes. The block pulls SDA low in each acknowledge slot that it accepts and otherwise leaves the line released.

A host sees a small status byte, the last received data byte and one interrupt line. An address match raises a flag that clears when the host reads the status byte. Each data byte raises a receive-full flag that clears when the host reads the data byte. A host-owned no-acknowledge bit chooses whether each data byte is acknowledged. An enable bit and a mode field gate the whole response, and an optional general-call enable lets the block also accept the all-zero address.

Top module: `i2c10_slave_rx`

## Requirements
- R1: A START (SDA falling while SCL is high) puts the block into first-address decode, and a STOP (SDA rising while SCL is high) returns it to idle. After reset the status byte reads 0x00, irq is low and SDA is released.
- R2: The first byte after a START is acknowledged only when bits [7:3] are 11110, bits [2:1] equal `cfg_addr_hi` and bit 0 (R/W) is 0. Any other first byte leaves SDA released.
- R3: A second address byte equal to `cfg_addr_lo` is acknowledged, sets the address-match flag (status bit 0), clears the direction flag (status bit 1) and makes irq high.
- R4: A host read of the status byte (`host_rd_en` with `host_rd_sel` = 0) clears the address-match flag on the next clock.
- R5: After each data byte, SDA is pulled low in the acknowledge slot when `cfg_nak` is 0 at the start of that slot, and left released when it is 1.
- R6: Every received data byte, whether acknowledged or not, is readable with `host_rd_sel` = 1, sets the receive-full flag (status bit 2) and makes irq high. A data read clears that flag.
- R7: The block answers only when `cfg_irq_en` is 1 and `cfg_mode` is 2'b01 (target only) or 2'b11 (controller/target). Otherwise every address byte is left unacknowledged.
- R8: With `cfg_gcall_en` = 1, a first byte of 0x00 is acknowledged, sets the address-match flag and the general-call flag (status bit 3), and the bytes after it are received as data.
- R9: A second address byte that differs from `cfg_addr_lo` is not acknowledged, and no later byte is acknowledged until the next START.
- R10: A repeated START in any phase restarts first-address decode, so a full address sequence after it is accepted.
- R11: The SDA drive changes only while SCL is low. It is released at the SCL falling edge that ends the acknowledge slot.
- R12: irq is high exactly when `cfg_irq_en` is 1 and the address-match or receive-full flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| sda_drive_low | output | 1 | 1 pulls SDA low (open drain) |
| cfg_mode | input | 2 | 00 off, 01 target only, 10 controller only, 11 controller/target |
| cfg_addr_hi | input | 2 | Address bits [9:8] |
| cfg_addr_lo | input | 8 | Address bits [7:0] |
| cfg_gcall_en | input | 1 | Also accept the general-call address |
| cfg_irq_en | input | 1 | Response and interrupt enable |
| cfg_nak | input | 1 | Refuse data bytes with no-acknowledge |
| host_rd_en | input | 1 | Host read strobe, one clock |
| host_rd_sel | input | 1 | 0 status byte, 1 received data byte |
| host_rd_data | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check the timing rules on every cycle. START, STOP and SCL edges never coincide. The SDA drive holds steady while SCL is high and stays off in the ignore phase. Accepted address and data bytes drive SDA, refused ones release it, rejected first bytes never drive it, and host reads clear their flags. Only the bench scenarios can show the transaction-level behaviour: which byte patterns are acknowledged from the master's side of the wired-AND bus, the value of each data byte, the effect of enable, mode and general-call settings, and recovery through repeated START.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

  localparam int BYTE_W    = 8;
  localparam int ADDR_HI_W = 2;
  localparam int MODE_W    = 2;

  localparam logic [4:0] TEN_BIT_MARK = 5'b11110;

  // status byte bit positions
  localparam int ST_MATCH_BIT = 0;
  localparam int ST_DIR_BIT   = 1;
  localparam int ST_FULL_BIT  = 2;
  localparam int ST_GCALL_BIT = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_DATA,
    PH_SKIP
  } phase_e;

  function automatic logic mode_answers(input logic [MODE_W-1:0] mode);
    return (mode == 2'b01) || (mode == 2'b11);
  endfunction

  function automatic logic hi_byte_ok(input logic [BYTE_W-1:0] b,
                                      input logic [ADDR_HI_W-1:0] hi);
    return (b[7:3] == TEN_BIT_MARK) && (b[2:1] == hi) && !b[0];
  endfunction

  function automatic logic lo_byte_ok(input logic [BYTE_W-1:0] b,
                                      input logic [BYTE_W-1:0] lo);
    return b == lo;
  endfunction

  function automatic logic gcall_ok(input logic [BYTE_W-1:0] b);
    return b == '0;
  endfunction

endpackage

// File: rtl/i2c10_line_sync.sv
module i2c10_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_prev, sda_prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_i;
          sda_chain <= sda_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[STAGES-2:0], scl_i};
          sda_chain <= {sda_chain[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  = scl_s && !scl_prev;
  assign scl_fall  = !scl_s && scl_prev;
  assign start_evt = scl_s && scl_prev && sda_prev && !sda_s;
  assign stop_evt  = scl_s && scl_prev && !sda_prev && sda_s;

  // R1
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt, scl_rise, scl_fall}));

endmodule

// File: rtl/i2c10_rx_fsm.sv
module i2c10_rx_fsm
  import i2c10_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_s,
  input  logic                 sda_s,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_evt,
  input  logic                 stop_evt,
  input  logic [MODE_W-1:0]    cfg_mode,
  input  logic [ADDR_HI_W-1:0] cfg_addr_hi,
  input  logic [BYTE_W-1:0]    cfg_addr_lo,
  input  logic                 cfg_gcall_en,
  input  logic                 cfg_irq_en,
  input  logic                 cfg_nak,
  output logic                 sda_low,
  output logic                 match_evt,
  output logic                 gcall_evt,
  output logic                 data_evt,
  output logic [BYTE_W-1:0]    rx_byte
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  phase_e            phase_q, phase_d;
  logic [BYTE_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ack_slot_q, drive_q;
  logic              receiving, byte_end, enabled, accept;
  logic              match_hit, gcall_hit, data_hit;

  assign receiving = (phase_q == PH_ADDR_HI) || (phase_q == PH_ADDR_LO) ||
                     (phase_q == PH_DATA);
  assign byte_end  = scl_fall && receiving && !ack_slot_q &&
                     (cnt_q == CNT_W'(BYTE_W));
  assign enabled   = cfg_irq_en && mode_answers(cfg_mode);

  always_comb begin
    accept    = 1'b0;
    phase_d   = PH_SKIP;
    match_hit = 1'b0;
    gcall_hit = 1'b0;
    data_hit  = 1'b0;
    case (phase_q)
      PH_ADDR_HI: begin
        if (enabled && hi_byte_ok(shreg_q, cfg_addr_hi)) begin
          accept  = 1'b1;
          phase_d = PH_ADDR_LO;
        end else if (enabled && cfg_gcall_en && gcall_ok(shreg_q)) begin
          accept    = 1'b1;
          phase_d   = PH_DATA;
          match_hit = 1'b1;
          gcall_hit = 1'b1;
        end
      end
      PH_ADDR_LO: begin
        if (enabled && lo_byte_ok(shreg_q, cfg_addr_lo)) begin
          accept    = 1'b1;
          phase_d   = PH_DATA;
          match_hit = 1'b1;
        end
      end
      PH_DATA: begin
        accept   = !cfg_nak;
        phase_d  = PH_DATA;
        data_hit = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      shreg_q    <= '0;
      cnt_q      <= '0;
      ack_slot_q <= 1'b0;
      drive_q    <= 1'b0;
    end else if (stop_evt) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      ack_slot_q <= 1'b0;
      drive_q    <= 1'b0;
    end else if (start_evt) begin
      phase_q    <= PH_ADDR_HI;
      cnt_q      <= '0;
      ack_slot_q <= 1'b0;
      drive_q    <= 1'b0;
    end else if (scl_rise && receiving && !ack_slot_q) begin
      shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
      cnt_q   <= cnt_q + 1'b1;
    end else if (scl_fall && ack_slot_q) begin
      ack_slot_q <= 1'b0;
      drive_q    <= 1'b0;
    end else if (byte_end) begin
      cnt_q      <= '0;
      phase_q    <= phase_d;
      drive_q    <= accept;
      ack_slot_q <= (phase_d != PH_SKIP);
    end
  end

  assign sda_low   = drive_q;
  assign match_evt = byte_end && match_hit;
  assign gcall_evt = byte_end && gcall_hit;
  assign data_evt  = byte_end && data_hit;
  assign rx_byte   = shreg_q;

  // R11
  drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_low));

  // R2
  mark_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && phase_q == PH_ADDR_HI && shreg_q[7:3] != TEN_BIT_MARK &&
     !(cfg_gcall_en && shreg_q == '0)) |=> !sda_low);

  // R3
  match_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> sda_low);

  // R5
  data_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_evt && cfg_nak) |=> !sda_low);

  // R5
  data_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_evt && !cfg_nak) |=> sda_low);

  // R9
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SKIP) |-> !sda_low);

endmodule

// File: rtl/i2c10_host_regs.sv
module i2c10_host_regs
  import i2c10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              match_evt,
  input  logic              gcall_evt,
  input  logic              data_evt,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              cfg_irq_en,
  input  logic              host_rd_en,
  input  logic              host_rd_sel,
  output logic [BYTE_W-1:0] host_rd_data,
  output logic              irq
);

  logic              match_q, dir_q, full_q, gcall_q;
  logic [BYTE_W-1:0] data_q;
  logic              rd_status, rd_data;
  logic [BYTE_W-1:0] status_byte;

  assign rd_status = host_rd_en && !host_rd_sel;
  assign rd_data   = host_rd_en && host_rd_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      dir_q   <= 1'b0;
      gcall_q <= 1'b0;
    end else if (match_evt) begin
      match_q <= 1'b1;
      dir_q   <= 1'b0;
      gcall_q <= gcall_evt;
    end else if (rd_status) begin
      match_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (data_evt) begin
      full_q <= 1'b1;
      data_q <= rx_byte;
    end else if (rd_data) begin
      full_q <= 1'b0;
    end
  end

  always_comb begin
    status_byte               = '0;
    status_byte[ST_MATCH_BIT] = match_q;
    status_byte[ST_DIR_BIT]   = dir_q;
    status_byte[ST_FULL_BIT]  = full_q;
    status_byte[ST_GCALL_BIT] = gcall_q;
  end

  assign host_rd_data = host_rd_sel ? data_q : status_byte;
  assign irq          = cfg_irq_en && (match_q || full_q);

  // R4
  match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !match_evt) |=> !match_q);

  // R6
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !data_evt) |=> !full_q);

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (match_q && !dir_q));

endmodule

// File: rtl/i2c10_slave_rx.sv
module i2c10_slave_rx
  import i2c10_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_drive_low,
  input  logic [MODE_W-1:0]    cfg_mode,
  input  logic [ADDR_HI_W-1:0] cfg_addr_hi,
  input  logic [BYTE_W-1:0]    cfg_addr_lo,
  input  logic                 cfg_gcall_en,
  input  logic                 cfg_irq_en,
  input  logic                 cfg_nak,
  input  logic                 host_rd_en,
  input  logic                 host_rd_sel,
  output logic [BYTE_W-1:0]    host_rd_data,
  output logic                 irq
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic match_evt, gcall_evt, data_evt;
  logic [BYTE_W-1:0] rx_byte;

  i2c10_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c10_rx_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_s        (scl_s),
    .sda_s        (sda_s),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_evt    (start_evt),
    .stop_evt     (stop_evt),
    .cfg_mode     (cfg_mode),
    .cfg_addr_hi  (cfg_addr_hi),
    .cfg_addr_lo  (cfg_addr_lo),
    .cfg_gcall_en (cfg_gcall_en),
    .cfg_irq_en   (cfg_irq_en),
    .cfg_nak      (cfg_nak),
    .sda_low      (sda_drive_low),
    .match_evt    (match_evt),
    .gcall_evt    (gcall_evt),
    .data_evt     (data_evt),
    .rx_byte      (rx_byte)
  );

  i2c10_host_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .match_evt    (match_evt),
    .gcall_evt    (gcall_evt),
    .data_evt     (data_evt),
    .rx_byte      (rx_byte),
    .cfg_irq_en   (cfg_irq_en),
    .host_rd_en   (host_rd_en),
    .host_rd_sel  (host_rd_sel),
    .host_rd_data (host_rd_data),
    .irq          (irq)
  );

  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |-> !irq);

endmodule

// File: tb/i2c10_slave_rx_bench.sv
module i2c10_slave_rx_bench;

  localparam int Q = 8;
  localparam logic [1:0] HI = 2'b10;
  localparam logic [7:0] LO = 8'h5A;
  // {first, second, data, nak, ack1, ack2, ack3}
  localparam logic [27:0] TBL [6] = '{
    {8'hF4, 8'h5A, 8'h3C, 4'b0111},
    {8'hF4, 8'h5A, 8'hC3, 4'b1110},
    {8'hF6, 8'h5A, 8'h11, 4'b0000},
    {8'hF5, 8'h5A, 8'h22, 4'b0000},
    {8'hF4, 8'h5B, 8'h33, 4'b0100},
    {8'hE4, 8'h5A, 8'h44, 4'b0000}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, scl_m, sda_m;
  logic sda_drive_low, irq;
  logic [1:0] cfg_mode;
  logic [1:0] cfg_addr_hi;
  logic [7:0] cfg_addr_lo;
  logic cfg_gcall_en, cfg_irq_en, cfg_nak;
  logic host_rd_en, host_rd_sel;
  logic [7:0] host_rd_data;
  wire  sda_bus = sda_m & ~sda_drive_low;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  i2c10_slave_rx u_i2c10_slave_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_drive_low(sda_drive_low), .cfg_mode(cfg_mode),
    .cfg_addr_hi(cfg_addr_hi), .cfg_addr_lo(cfg_addr_lo),
    .cfg_gcall_en(cfg_gcall_en), .cfg_irq_en(cfg_irq_en), .cfg_nak(cfg_nak),
    .host_rd_en(host_rd_en), .host_rd_sel(host_rd_sel),
    .host_rd_data(host_rd_data), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = !sda_bus;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic host_read(input bit sel, output logic [7:0] val);
    @(negedge clk);
    host_rd_sel = sel;
    host_rd_en  = 1'b1;
    #1 val = host_rd_data;
    @(negedge clk);
    host_rd_en  = 1'b0;
    host_rd_sel = 1'b0;
  endtask

  task automatic peek_status(output logic [7:0] val);
    @(negedge clk);
    host_rd_sel = 1'b0;
    #1 val = host_rd_data;
  endtask

  task automatic drain();
    logic [7:0] v;
    host_read(1'b0, v);
    host_read(1'b1, v);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a1, a2, a3, a4;
    logic [7:0] v;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    cfg_mode = 2'b01; cfg_addr_hi = HI; cfg_addr_lo = LO;
    cfg_gcall_en = 1'b0; cfg_irq_en = 1'b1; cfg_nak = 1'b0;
    host_rd_en = 1'b0; host_rd_sel = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    peek_status(v);
    check(v == 8'h00, "R1 reset status", v, 0);
    check(irq == 1'b0, "R12 reset irq", irq, 0);
    check(sda_drive_low == 1'b0, "R1 reset sda", sda_drive_low, 0);

    // vector table: R2 R3 R5 R6 R9
    for (int k = 0; k < 6; k++) begin
      logic [27:0] e;
      e = TBL[k];
      cfg_nak = e[3];
      bus_start();
      send_byte(e[27:20], a1);
      send_byte(e[19:12], a2);
      send_byte(e[11:4], a3);
      bus_stop();
      check(a1 == e[2], "R2 first byte ack", a1, e[2]);
      check(a2 == e[1], "R3/R9 second byte ack", a2, e[1]);
      check(a3 == e[0], "R5/R9 data ack", a3, e[0]);
      check(sda_drive_low == 1'b0, "R11 released after stop", sda_drive_low, 0);
      if (e[1]) begin
        host_read(1'b0, v);
        check(v == 8'h05, "R3/R6 status after transfer", v, 5);
        check(irq == 1'b1, "R12 irq with full flag", irq, 1);
        peek_status(v);
        check(v == 8'h04, "R4 match cleared by status read", v, 4);
        host_read(1'b1, v);
        check(v == e[11:4], "R6 data byte", v, e[11:4]);
        peek_status(v);
        check(v == 8'h00, "R6 full cleared by data read", v, 0);
        check(irq == 1'b0, "R12 irq after reads", irq, 0);
      end else begin
        peek_status(v);
        check(v == 8'h00, "R9 no flags on mismatch", v, 0);
        check(irq == 1'b0, "R12 irq idle", irq, 0);
      end
    end
    cfg_nak = 1'b0;

    // R7 enable off
    cfg_irq_en = 1'b0;
    bus_start(); send_byte(8'hF4, a1); bus_stop();
    check(a1 == 1'b0, "R7 disabled no ack", a1, 0);
    cfg_irq_en = 1'b1;
    // R7 controller-only mode
    cfg_mode = 2'b10;
    bus_start(); send_byte(8'hF4, a1); bus_stop();
    check(a1 == 1'b0, "R7 mode 10 no ack", a1, 0);
    // R7 controller/target mode
    cfg_mode = 2'b11;
    bus_start(); send_byte(8'hF4, a1); send_byte(LO, a2); send_byte(8'h6E, a3); bus_stop();
    check(a1 && a2 && a3, "R7 mode 11 acks", {a1, a2, a3}, 7);
    host_read(1'b1, v);
    check(v == 8'h6E, "R7 mode 11 data", v, 8'h6E);
    drain();
    cfg_mode = 2'b01;

    // R8 general call off then on
    bus_start(); send_byte(8'h00, a1); bus_stop();
    check(a1 == 1'b0, "R8 general call disabled", a1, 0);
    cfg_gcall_en = 1'b1;
    bus_start(); send_byte(8'h00, a1); send_byte(8'h99, a2); bus_stop();
    check(a1 && a2, "R8 general call acks", {a1, a2}, 3);
    host_read(1'b0, v);
    check(v == 8'h0D, "R8 general call status", v, 8'h0D);
    host_read(1'b1, v);
    check(v == 8'h99, "R8 general call data", v, 8'h99);
    drain();
    cfg_gcall_en = 1'b0;

    // R10 repeated start after accepted first byte
    bus_start(); send_byte(8'hF4, a1);
    bus_start(); send_byte(8'hF4, a2); send_byte(LO, a3); send_byte(8'h77, a4); bus_stop();
    check(a1 && a2 && a3 && a4, "R10 repeated start acks", {a1, a2, a3, a4}, 15);
    host_read(1'b1, v);
    check(v == 8'h77, "R10 data after repeated start", v, 8'h77);
    drain();

    // R1/R10 repeated start after an ignored byte
    bus_start(); send_byte(8'h12, a1);
    bus_start(); send_byte(8'hF4, a2); bus_stop();
    check(!a1 && a2, "R1 recover via repeated start", {a1, a2}, 1);
    check(sda_drive_low == 1'b0, "R11 released after ack slot", sda_drive_low, 0);
    drain();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule